// File: doc/BRIEF.md
# Four-Lane Local Fault Ordered-Set Injector

This block sits in the transmit character path of a four-lane link, downstream of the character decoder. Every clock it takes one column: an 8-bit character and a control flag per lane. Several fault sources feed it: per-lane signal loss, per-lane loss of character synchronization, loss of alignment between lanes, and an unlocked transmit PLL. Any one of them is enough to raise a local fault. While a local fault is in force and fault propagation is enabled, each outgoing column is replaced by the local-fault sequence ordered set. Otherwise received columns go out unchanged, and that includes any fault ordered sets already in the stream.

The output is registered, so a column appears one clock after it is presented. A fault condition is stretched by a programmable number of clear columns before normal data resumes. A status output reports the fault state whether or not propagation is enabled. Because every clock carries a whole column, replacement starts and stops only between columns, and a partial ordered set is never sent.

Top module: `lf_seq_inject`

## Requirements
- R1: While reset is asserted, `out_data`, `out_ctrl` and `fault_out` are all zero. Reset is applied at once and released after two clock edges, and it clears any fault hold in progress.
- R2: Each of these sources, alone, makes `fault_out` high one clock later: any bit of `los`, any bit of `sync_lost`, `align_lost`, `pll_unlock`.
- R3: When a fault is in force and `prop_en` is high, the next output column is the local-fault ordered set. Lane n occupies bits [8n+7:8n]. Lane 0 carries 0x9C (K28.4) with its control flag set. Lanes 1 and 2 carry 0x00 (D0.0) and lane 3 carries 0x01 (D1.0), all three with the control flag clear. `out_ctrl` is therefore 4'b0001.
- R4: When no fault is in force, the output column one clock later equals the input column, data and control flags, and `fault_out` is low.
- R5: A received sequence ordered set (0x9C with its control flag set on lane 0) is forwarded unchanged when no fault is in force. This holds for the remote-fault set 0x02 on lane 3 and for the local-fault set 0x01 on lane 3.
- R6: With `prop_en` low, faults still raise `fault_out`, but the output column equals the input column.
- R7: After every fault source clears, the fault stays in force for HOLD_COLS further columns, and normal data resumes on the column after that. With HOLD_COLS=3 and a fault present in a single column, four consecutive output columns are injected.
- R8: A fault that reappears during the hold period restarts the full HOLD_COLS count.
- R9: Every output column is either the complete local-fault set or an exact copy of the previous input column. No column mixes the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | LANES*CHAR_W | Received column characters, lane 0 in the low byte |
| in_ctrl | input | LANES | Per-lane control flags of the received column |
| los | input | LANES | Per-lane signal loss or signal-detect failure |
| sync_lost | input | LANES | Per-lane loss of character synchronization |
| align_lost | input | 1 | Lane alignment lost |
| pll_unlock | input | 1 | Transmit PLL not locked |
| prop_en | input | 1 | Fault propagation enable |
| out_data | output | LANES*CHAR_W | Transmitted column characters |
| out_ctrl | output | LANES | Per-lane control flags of the transmitted column |
| fault_out | output | 1 | Local fault status, one column behind the inputs |

## Verification
The bench builds the block with HOLD_COLS=3 and the default four 8-bit lanes. A hold longer than one column separates a fresh countdown from one restarted partway through. It also makes the exact column on which normal data resumes observable, rather than something a single-cycle latch would also produce. At that setting the bench can drive a second fault source into the middle of a countdown and watch the hold stretch, and it can enable propagation only after a countdown has already begun.

// File: rtl/lf_inj_pkg.sv
package lf_inj_pkg;

  localparam logic [7:0] CH_K28_4 = 8'h9C;
  localparam logic [7:0] CH_D0_0  = 8'h00;
  localparam logic [7:0] CH_D1_0  = 8'h01;
  localparam int         SET_LEN  = 4;

  // Character of the local-fault set for a given lane position.
  function automatic logic [7:0] lf_char(input int lane);
    case (lane % SET_LEN)
      0:       return CH_K28_4;
      3:       return CH_D1_0;
      default: return CH_D0_0;
    endcase
  endfunction

  // Control flag of the local-fault set for a given lane position.
  function automatic logic lf_ctrl(input int lane);
    return (lane % SET_LEN) == 0;
  endfunction

endpackage

// File: rtl/lf_rst_sync.sv
module lf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lf_fault_merge.sv
module lf_fault_merge #(
  parameter int LANES     = 4,
  parameter int HOLD_COLS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] los,
  input  logic [LANES-1:0] sync_lost,
  input  logic             align_lost,
  input  logic             pll_unlock,
  output logic             fault_now
);

  localparam int CNT_W = (HOLD_COLS > 0) ? $clog2(HOLD_COLS + 1) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_COLS);

  logic             raw_fault;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] hold_d;
  logic             hold_en;
  logic             hold_busy;

  assign raw_fault = (|los) | (|sync_lost) | align_lost | pll_unlock;
  assign hold_busy = (hold_q != '0);

  // Next-state: reload on any fault, count down through clear columns.
  always_comb begin
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (raw_fault) begin
      hold_d  = HOLD_LOAD;
      hold_en = 1'b1;
    end else if (hold_busy) begin
      hold_d  = hold_q - 1'b1;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign fault_now = raw_fault | hold_busy;

endmodule

// File: rtl/lf_column_mux.sv
module lf_column_mux #(
  parameter int LANES  = 4,
  parameter int CHAR_W = 8
) (
  input  logic [LANES*CHAR_W-1:0] col_data,
  input  logic [LANES-1:0]        col_ctrl,
  input  logic                    inject,
  output logic [LANES*CHAR_W-1:0] mux_data,
  output logic [LANES-1:0]        mux_ctrl
);

  import lf_inj_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [CHAR_W-1:0] SET_CHAR = CHAR_W'(lf_char(g));
    localparam logic              SET_CTRL = lf_ctrl(g);

    assign mux_data[g*CHAR_W +: CHAR_W] = inject ? SET_CHAR : col_data[g*CHAR_W +: CHAR_W];
    assign mux_ctrl[g]                  = inject ? SET_CTRL : col_ctrl[g];
  end

endmodule

// File: rtl/lf_seq_inject.sv
module lf_seq_inject #(
  parameter int LANES      = 4,
  parameter int CHAR_W     = 8,
  parameter int HOLD_COLS  = 1,
  parameter int RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*CHAR_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  input  logic [LANES-1:0]        los,
  input  logic [LANES-1:0]        sync_lost,
  input  logic                    align_lost,
  input  logic                    pll_unlock,
  input  logic                    prop_en,
  output logic [LANES*CHAR_W-1:0] out_data,
  output logic [LANES-1:0]        out_ctrl,
  output logic                    fault_out
);

  localparam int COL_W = LANES * CHAR_W;

  logic             rst_core_n;
  logic             fault_now;
  logic             inject;
  logic [COL_W-1:0] mux_data;
  logic [LANES-1:0] mux_ctrl;
  logic [COL_W-1:0] out_data_d;
  logic [LANES-1:0] out_ctrl_d;
  logic             fault_d;

  lf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_core_n)
  );

  lf_fault_merge #(.LANES(LANES), .HOLD_COLS(HOLD_COLS)) u_fault (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .los        (los),
    .sync_lost  (sync_lost),
    .align_lost (align_lost),
    .pll_unlock (pll_unlock),
    .fault_now  (fault_now)
  );

  assign inject = prop_en & fault_now;

  lf_column_mux #(.LANES(LANES), .CHAR_W(CHAR_W)) u_mux (
    .col_data (in_data),
    .col_ctrl (in_ctrl),
    .inject   (inject),
    .mux_data (mux_data),
    .mux_ctrl (mux_ctrl)
  );

  always_comb begin
    out_data_d = mux_data;
    out_ctrl_d = mux_ctrl;
    fault_d    = fault_now;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_data  <= '0;
      out_ctrl  <= '0;
      fault_out <= 1'b0;
    end else begin
      out_data  <= out_data_d;
      out_ctrl  <= out_ctrl_d;
      fault_out <= fault_d;
    end
  end

endmodule

// File: rtl/lf_seq_inject_chk.sv
module lf_seq_inject_chk #(
  parameter int LANES  = 4,
  parameter int CHAR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*CHAR_W-1:0] in_data,
  input logic [LANES-1:0]        in_ctrl,
  input logic [LANES-1:0]        los,
  input logic [LANES-1:0]        sync_lost,
  input logic                    align_lost,
  input logic                    pll_unlock,
  input logic                    prop_en,
  input logic [LANES*CHAR_W-1:0] out_data,
  input logic [LANES-1:0]        out_ctrl,
  input logic                    fault_out
);

  import lf_inj_pkg::*;

  logic [LANES*CHAR_W-1:0] set_data;
  logic [LANES-1:0]        set_ctrl;
  logic                    any_src;
  logic                    out_is_set;

  for (genvar g = 0; g < LANES; g++) begin : g_set
    assign set_data[g*CHAR_W +: CHAR_W] = CHAR_W'(lf_char(g));
    assign set_ctrl[g]                  = lf_ctrl(g);
  end

  assign any_src    = (|los) | (|sync_lost) | align_lost | pll_unlock;
  assign out_is_set = (out_data == set_data) && (out_ctrl == set_ctrl);

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (out_data == '0) && (out_ctrl == '0) && !fault_out);

  p_source_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> fault_out);

  p_inject_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_src && prop_en) |=> out_is_set);

  p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_src && !fault_out) |=>
      (out_data == $past(in_data)) && (out_ctrl == $past(in_ctrl)) && !fault_out);

  p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prop_en |=> (out_data == $past(in_data)) && (out_ctrl == $past(in_ctrl)));

  p_hold_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(any_src) && prop_en) |=> out_is_set);

  p_whole_column_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_is_set ||
      ((out_data == $past(in_data)) && (out_ctrl == $past(in_ctrl))));

endmodule

bind lf_seq_inject lf_seq_inject_chk #(.LANES(LANES), .CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .in_data    (in_data),
  .in_ctrl    (in_ctrl),
  .los        (los),
  .sync_lost  (sync_lost),
  .align_lost (align_lost),
  .pll_unlock (pll_unlock),
  .prop_en    (prop_en),
  .out_data   (out_data),
  .out_ctrl   (out_ctrl),
  .fault_out  (fault_out)
);

// File: tb/lf_seq_inject_test.sv
`timescale 1ns/1ps
module lf_seq_inject_test;

  localparam int LANES = 4;
  localparam int CHAR_W = 8;
  localparam int HOLD = 3;
  localparam logic [31:0] LFD = 32'h0100009C;
  localparam logic [3:0]  LFC = 4'h1;

  typedef struct packed {
    logic [31:0] d; logic [3:0] c; logic [3:0] ls; logic [3:0] sl;
    logic al; logic pl; logic en;
    logic [31:0] ed; logic [3:0] ec; logic ef;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'hA1B2C3D4, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'hA1B2C3D4, 4'h0, 1'b0},
    '{32'h07070707, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h07070707, 4'hF, 1'b0},
    '{32'h0200009C, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0200009C, 4'h1, 1'b0},
    '{32'h0100009C, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0100009C, 4'h1, 1'b0},
    '{32'h11223344, 4'h0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h55667788, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h55667788, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h55667788, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h99AABBCC, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h99AABBCC, 4'h0, 1'b0},
    '{32'hDEADBEEF, 4'h2, 4'h0, 4'h8, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 4'h2, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'h12345678, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, LFD, LFC, 1'b1},
    '{32'hCAFEF00D, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 32'hCAFEF00D, 4'h0, 1'b0},
    '{32'h0100009C, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0100009C, 4'h1, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] in_data;
  logic [3:0]  in_ctrl;
  logic [3:0]  los;
  logic [3:0]  sync_lost;
  logic        align_lost;
  logic        pll_unlock;
  logic        prop_en;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;
  logic        fault_out;

  int n_run;
  int n_fail;

  lf_seq_inject #(.LANES(LANES), .CHAR_W(CHAR_W), .HOLD_COLS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .los(los), .sync_lost(sync_lost), .align_lost(align_lost),
    .pll_unlock(pll_unlock), .prop_en(prop_en),
    .out_data(out_data), .out_ctrl(out_ctrl), .fault_out(fault_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string tag_of(input int i);
    case (i)
      0, 1:          return "R4";
      2, 3:          return "R5";
      4:             return "R3";
      5, 6, 7, 8:    return "R7";
      9, 19:         return "R6";
      10:            return "R7";
      11, 12, 13:    return "R8";
      14:            return "R2";
      15, 16, 17:    return "R8";
      default:       return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual fault/ctrl/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [3:0] c, input logic [3:0] ls,
                       input logic [3:0] sl, input logic al, input logic pl, input logic en);
    in_data = d; in_ctrl = c; los = ls; sync_lost = sl;
    align_lost = al; pll_unlock = pl; prop_en = en;
  endtask

  task automatic step_check(input string tag, input logic [31:0] ed, input logic [3:0] ec,
                            input logic ef);
    @(posedge clk);
    #2;
    check(tag, {fault_out, out_ctrl, out_data}, {ef, ec, ed});
  endtask

  task automatic flush();
    for (int k = 0; k < HOLD + 1; k++) begin
      @(negedge clk);
      drive(32'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
    end
    step_check("R7", 32'h0, 4'h0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    drive(32'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #2;
    check("R1", {fault_out, out_ctrl, out_data}, 37'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].d, VECS[i].c, VECS[i].ls, VECS[i].sl, VECS[i].al, VECS[i].pl, VECS[i].en);
      step_check(tag_of(i), VECS[i].ed, VECS[i].ec, VECS[i].ef);
    end

    // R2: each per-lane source alone
    for (int ln = 0; ln < LANES; ln++) begin
      @(negedge clk);
      drive(32'h5A5A5A5A, 4'h0, 4'(1 << ln), 4'h0, 1'b0, 1'b0, 1'b1);
      step_check("R2", LFD, LFC, 1'b1);
      flush();
      @(negedge clk);
      drive(32'hA5A5A5A5, 4'h0, 4'h0, 4'(1 << ln), 1'b0, 1'b0, 1'b1);
      step_check("R2", LFD, LFC, 1'b1);
      flush();
    end

    // R1: reset during an active fault clears outputs and the hold
    @(negedge clk);
    drive(32'h24682468, 4'h0, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1);
    step_check("R3", LFD, LFC, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {fault_out, out_ctrl, out_data}, 37'h0);
    @(negedge clk);
    drive(32'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    drive(32'h13579BDF, 4'h8, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
    step_check("R1", 32'h13579BDF, 4'h8, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule